// File: doc/BRIEF.md
# Zero-Cross Gain Update Controller

This block sets the volume of a stereo digital audio path. Each channel has its own 7-bit gain code, loaded through a simple write port that carries a channel select. A code can take effect at the next sample, or it can wait as a pending value until that channel's waveform crosses zero. Waiting for a crossing prevents clicks and zipper noise when the volume changes. An optional sample-count timeout forces the pending code in if no crossing arrives in time. Low codes mute the channel. A per-channel enable silences the output completely.

Samples arrive as signed 16-bit words with a common strobe. One cycle after each strobe, the block presents both scaled samples together with a valid flag. Between strobes it holds the last results. The active gain codes and the mute flags are visible at the ports.

Top module: `zc_gain_ctrl`

## Requirements
- R1: While `rst_ni` is low, both active gain codes are 0, both mute flags are 1, `out_vld_o` is 0 and both sample outputs are 0.
- R2: A write with `wr_sel_i`=0 targets only the left channel and `wr_sel_i`=1 targets only the right. The other channel's active and pending codes are unchanged.
- R3: With `zc_en_i`=0, a written code becomes active at the first strobe after the write cycle. That strobe's sample is already scaled with the new code. A strobe in the write cycle itself does not apply the code.
- R4: With `zc_en_i`=1, a pending code is applied at the first later strobe whose sample is a crossing. A crossing is a sample that is exactly 0, or whose sign bit differs from the sign bit of the channel's previous strobed sample. The previous sign is taken as positive after reset. The crossing sample is scaled with the new code.
- R5: With `zc_en_i`=1 and `to_en_i`=1, a pending code is applied no later than the L-th strobe after the write, where L = 2^(10+2·`to_div_i`).
- R6: A write to a channel that already holds a pending code replaces that code and restarts the timeout count from zero.
- R7: The gain step is g = max(code,48) − 121 dB, so the range is −73 to +6 and code 121 is unity. With e = g+78, the multiplier is M[e mod 6]·2^(e div 6), where M = {16384, 18383, 20626, 23143, 25967, 29135}. The output is floor(sample·multiplier / 2^27).
- R8: Scaled results above 32767 or below −32768 saturate to those limits.
- R9: Codes below 47 raise the channel's mute flag and produce output 0. Code 47 is not muted and scales like code 48.
- R10: When a channel's enable is low, its mute flag is 1 and its strobed output is 0. Gain updates continue to happen as usual.
- R11: `out_vld_o` is high exactly in the cycle after a strobe. Sample outputs and active gain codes change only on the edge that closes a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Gain write strobe |
| wr_sel_i | input | 1 | Write target: 0 left, 1 right |
| wr_code_i | input | 7 | Gain code written |
| chan_en_i | input | 2 | Channel enables, bit 0 left, bit 1 right |
| zc_en_i | input | 1 | Hold updates for a zero crossing |
| to_en_i | input | 1 | Allow the timeout to force a pending update |
| to_div_i | input | 2 | Timeout select n, L = 2^(10+2n) strobes |
| smp_vld_i | input | 1 | Sample strobe |
| smp_l_i | input | 16 | Left signed sample |
| smp_r_i | input | 16 | Right signed sample |
| gain_l_o | output | 7 | Active left gain code |
| gain_r_o | output | 7 | Active right gain code |
| mute_o | output | 2 | Mute flags, bit 0 left, bit 1 right |
| out_vld_o | output | 1 | Scaled samples valid |
| out_l_o | output | 16 | Scaled left sample |
| out_r_o | output | 16 | Scaled right sample |

## Verification
Several sample sequences test when an update happens. Runs of a single sign must leave a pending code waiting. A sign flip applies it, and so does an exact zero, which shows that crossings are detected both ways. Long constant-sign runs of just under and exactly the timeout length check the count boundary for two divider settings. A rewrite in the middle of a run shows that the count restarts. Full-scale samples at +6 dB check saturation, mid-range samples at known codes check the arithmetic, and a long randomized mix of writes, strobes and mode changes is compared every cycle against a behavioural model.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  localparam int MUTE_BELOW = 47;  // codes below this are muted
  localparam int FLOOR_CODE = 48;  // lowest code with its own step
  localparam int E_OFFSET   = 43;  // e = code - 121 + 78
  localparam int MANT_F     = 14;  // mantissa fraction bits
  localparam int UNITY_EXP  = 13;  // e div 6 at unity gain
  localparam int SHIFT      = MANT_F + UNITY_EXP;

  // 10^(r/20) in Q1.14
  function automatic logic [14:0] mant_f(input logic [2:0] r);
    case (r)
      3'd1:    return 15'd18383;
      3'd2:    return 15'd20626;
      3'd3:    return 15'd23143;
      3'd4:    return 15'd25967;
      3'd5:    return 15'd29135;
      default: return 15'd16384;
    endcase
  endfunction
endpackage

// File: rtl/zc_gain_scaler.sv
module zc_gain_scaler
  import zc_gain_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 7
) (
  input  logic signed [DW-1:0] smp_i,
  input  logic [CW-1:0]        code_i,
  input  logic                 en_i,
  output logic signed [DW-1:0] y_o
);
  localparam int MUL_W = 30;
  localparam int PW    = DW + MUL_W + 1;
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [CW-1:0]         c_clamp;
  logic [CW-1:0]         e;
  logic [3:0]            q;
  logic [2:0]            r;
  logic [MUL_W-1:0]      mult;
  logic signed [PW-1:0]  a_ext, b_ext, prod, shf;

  always_comb begin
    c_clamp = (code_i < CW'(FLOOR_CODE)) ? CW'(FLOOR_CODE) : code_i;
    e       = c_clamp - CW'(E_OFFSET);
    q       = 4'(e / CW'(6));
    r       = 3'(e % CW'(6));
    mult    = MUL_W'(mant_f(r)) << q;
    a_ext   = PW'(smp_i);
    b_ext   = PW'(mult);
    prod    = a_ext * b_ext;
    shf     = prod >>> SHIFT;
    if (!en_i || code_i < CW'(MUTE_BELOW)) y_o = '0;
    else if (shf > SAT_HI)                 y_o = SAT_HI[DW-1:0];
    else if (shf < SAT_LO)                 y_o = SAT_LO[DW-1:0];
    else                                   y_o = shf[DW-1:0];
  end
endmodule

// File: rtl/zc_gain_chan.sv
module zc_gain_chan
  import zc_gain_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 7,
  parameter int DIV_W   = 2,
  parameter int TO_BASE = 10,
  parameter int TO_STEP = 2,
  parameter int TO_W    = 17
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [CW-1:0]        code_i,
  input  logic                 zc_en_i,
  input  logic                 to_en_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 en_i,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] smp_i,
  output logic [CW-1:0]        gain_o,
  output logic                 mute_o,
  output logic signed [DW-1:0] y_o
);
  logic [CW-1:0]        act_q, pend_code_q, eff_code;
  logic                 pend_q, sign_q;
  logic [TO_W-1:0]      cnt_q, cnt_inc, limit;
  logic                 crossing, timed_out, apply;
  logic signed [DW-1:0] y_d, y_q;
  int                   to_exp;

  always_comb begin
    crossing  = (smp_i == '0) || (smp_i[DW-1] != sign_q);
    cnt_inc   = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    to_exp    = TO_BASE + TO_STEP * int'(div_i);
    limit     = TO_W'(1) << to_exp;
    timed_out = to_en_i && (cnt_inc >= limit);
    apply     = smp_vld_i && !wr_i && pend_q && (!zc_en_i || crossing || timed_out);
    eff_code  = apply ? pend_code_q : act_q;
  end

  zc_gain_scaler #(.DW(DW), .CW(CW)) u_scaler (
    .smp_i  (smp_i),
    .code_i (eff_code),
    .en_i   (en_i),
    .y_o    (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= '0;
      pend_code_q <= '0;
      pend_q      <= 1'b0;
      cnt_q       <= '0;
      sign_q      <= 1'b0;
      y_q         <= '0;
    end else begin
      if (wr_i) begin
        pend_code_q <= code_i;
        pend_q      <= 1'b1;
        cnt_q       <= '0;
      end else if (apply) begin
        act_q  <= pend_code_q;
        pend_q <= 1'b0;
      end else if (smp_vld_i && pend_q) begin
        cnt_q <= cnt_inc;
      end
      if (smp_vld_i) begin
        sign_q <= smp_i[DW-1];
        y_q    <= y_d;
      end
    end
  end

  assign gain_o = act_q;
  assign mute_o = !en_i || (act_q < CW'(MUTE_BELOW));
  assign y_o    = y_q;
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int DW      = 16,
  parameter int CW      = 7,
  parameter int DIV_W   = 2,
  parameter int TO_BASE = 10,
  parameter int TO_STEP = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [CW-1:0]        wr_code_i,
  input  logic [1:0]           chan_en_i,
  input  logic                 zc_en_i,
  input  logic                 to_en_i,
  input  logic [DIV_W-1:0]     to_div_i,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] smp_l_i,
  input  logic signed [DW-1:0] smp_r_i,
  output logic [CW-1:0]        gain_l_o,
  output logic [CW-1:0]        gain_r_o,
  output logic [1:0]           mute_o,
  output logic                 out_vld_o,
  output logic signed [DW-1:0] out_l_o,
  output logic signed [DW-1:0] out_r_o
);
  localparam int NCH        = 2;
  localparam int TO_MAX_EXP = TO_BASE + TO_STEP * ((1 << DIV_W) - 1);
  localparam int TO_W       = TO_MAX_EXP + 1;

  logic signed [DW-1:0] smp_a [NCH];
  logic signed [DW-1:0] y_a   [NCH];
  logic [CW-1:0]        gain_a[NCH];
  logic                 vld_q;

  assign smp_a[0] = smp_l_i;
  assign smp_a[1] = smp_r_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zc_gain_chan #(
      .DW(DW), .CW(CW), .DIV_W(DIV_W),
      .TO_BASE(TO_BASE), .TO_STEP(TO_STEP), .TO_W(TO_W)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i && (int'(wr_sel_i) == c)),
      .code_i    (wr_code_i),
      .zc_en_i   (zc_en_i),
      .to_en_i   (to_en_i),
      .div_i     (to_div_i),
      .en_i      (chan_en_i[c]),
      .smp_vld_i (smp_vld_i),
      .smp_i     (smp_a[c]),
      .gain_o    (gain_a[c]),
      .mute_o    (mute_o[c]),
      .y_o       (y_a[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= smp_vld_i;
  end

  assign gain_l_o  = gain_a[0];
  assign gain_r_o  = gain_a[1];
  assign out_l_o   = y_a[0];
  assign out_r_o   = y_a[1];
  assign out_vld_o = vld_q;
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk #(
  parameter int DW = 16,
  parameter int CW = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 wr_sel_i,
  input logic [CW-1:0]        wr_code_i,
  input logic [1:0]           chan_en_i,
  input logic                 zc_en_i,
  input logic                 to_en_i,
  input logic                 smp_vld_i,
  input logic signed [DW-1:0] smp_l_i,
  input logic signed [DW-1:0] smp_r_i,
  input logic [CW-1:0]        gain_l_o,
  input logic [CW-1:0]        gain_r_o,
  input logic [1:0]           mute_o,
  input logic                 out_vld_o,
  input logic signed [DW-1:0] out_l_o,
  input logic signed [DW-1:0] out_r_o
);
  logic [CW-1:0] last_l, last_r;
  logic          sgn_l, sgn_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_l <= '0;
      last_r <= '0;
      sgn_l  <= 1'b0;
      sgn_r  <= 1'b0;
    end else begin
      if (wr_en_i && !wr_sel_i) last_l <= wr_code_i;
      if (wr_en_i &&  wr_sel_i) last_r <= wr_code_i;
      if (smp_vld_i) begin
        sgn_l <= smp_l_i[DW-1];
        sgn_r <= smp_r_i[DW-1];
      end
    end
  end

  // R11
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> out_vld_o);
  // R11
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !out_vld_o);
  // R11
  gain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ($stable(gain_l_o) && $stable(gain_r_o)));
  // R3
  direct_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !zc_en_i && !(wr_en_i && !wr_sel_i)) |=> (gain_l_o == $past(last_l)));
  // R3
  direct_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !zc_en_i && !(wr_en_i && wr_sel_i)) |=> (gain_r_o == $past(last_r)));
  // R4
  zc_hold_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && zc_en_i && !to_en_i && smp_l_i != '0 && smp_l_i[DW-1] == sgn_l)
      |=> $stable(gain_l_o));
  // R4
  zc_hold_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && zc_en_i && !to_en_i && smp_r_i != '0 && smp_r_i[DW-1] == sgn_r)
      |=> $stable(gain_r_o));
  // R10
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !chan_en_i[0]) |=> (out_l_o == '0));
  // R9
  low_code_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_r_o < CW'(47)) |-> mute_o[1]);
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_code_i (wr_code_i),
  .chan_en_i (chan_en_i),
  .zc_en_i   (zc_en_i),
  .to_en_i   (to_en_i),
  .smp_vld_i (smp_vld_i),
  .smp_l_i   (smp_l_i),
  .smp_r_i   (smp_r_i),
  .gain_l_o  (gain_l_o),
  .gain_r_o  (gain_r_o),
  .mute_o    (mute_o),
  .out_vld_o (out_vld_o),
  .out_l_o   (out_l_o),
  .out_r_o   (out_r_o)
);

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, wr_en, wr_sel, zc_en, to_en, smp_vld;
  logic [6:0]        wr_code;
  logic [1:0]        chan_en, to_div;
  logic signed [15:0] smp_l, smp_r;
  logic [6:0]        gain_l, gain_r;
  logic [1:0]        mute;
  logic              out_vld;
  logic signed [15:0] out_l, out_r;

  zc_gain_ctrl u_zc_gain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_code_i(wr_code), .chan_en_i(chan_en), .zc_en_i(zc_en), .to_en_i(to_en),
    .to_div_i(to_div), .smp_vld_i(smp_vld), .smp_l_i(smp_l), .smp_r_i(smp_r),
    .gain_l_o(gain_l), .gain_r_o(gain_r), .mute_o(mute), .out_vld_o(out_vld),
    .out_l_o(out_l), .out_r_o(out_r)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  int m_act[2], m_pc[2], m_pend[2], m_cnt[2], m_sgn[2], m_out[2], m_vld;

  function automatic longint mant(int r);
    case (r)
      1: return 18383; 2: return 20626; 3: return 23143;
      4: return 25967; 5: return 29135; default: return 16384;
    endcase
  endfunction

  // R7 R8 R9 R10 arithmetic, from the requirement text
  function automatic int scale(int x, int code, bit en);
    int c, e; longint p;
    if (!en || code < 47) return 0;
    c = (code < 48) ? 48 : code;
    e = c - 121 + 78;
    p = longint'(x) * (mant(e % 6) << (e / 6));
    p = p >>> 27;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_act[c] = 0; m_pc[c] = 0; m_pend[c] = 0; m_cnt[c] = 0; m_sgn[c] = 0; m_out[c] = 0;
      end
      m_vld = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit wrt, apply, zc;
        int x, eff;
        wrt = wr_en && (int'(wr_sel) == c);
        apply = 0;
        if (smp_vld) begin
          x = (c == 0) ? int'(smp_l) : int'(smp_r);
          zc = (x == 0) || ((x < 0) != (m_sgn[c] != 0));
          m_sgn[c] = (x < 0);
          if (!wrt && m_pend[c] != 0) begin
            m_cnt[c]++;
            if (!zc_en || zc || (to_en && m_cnt[c] >= (1 << (10 + 2 * int'(to_div))))) apply = 1;
          end
          eff = apply ? m_pc[c] : m_act[c];
          m_out[c] = scale(x, eff, chan_en[c]);
        end
        if (wrt) begin
          m_pc[c] = int'(wr_code); m_pend[c] = 1; m_cnt[c] = 0;
        end else if (apply) begin
          m_act[c] = m_pc[c]; m_pend[c] = 0;
        end
      end
      m_vld = smp_vld;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4", int'(gain_l), m_act[0], "gain_l");
      chk("R4", int'(gain_r), m_act[1], "gain_r");
      chk("R7", int'(out_l), m_out[0], "out_l");
      chk("R7", int'(out_r), m_out[1], "out_r");
      chk("R9", int'(mute[0]), int'(!chan_en[0] || m_act[0] < 47), "mute_l");
      chk("R9", int'(mute[1]), int'(!chan_en[1] || m_act[1] < 47), "mute_r");
      chk("R11", int'(out_vld), m_vld, "out_vld");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    report();
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit sel, int code);
    wr_en = 1; wr_sel = sel; wr_code = 7'(code);
    tick(1);
    wr_en = 0;
  endtask

  task automatic strobe(int l, int r);
    smp_vld = 1; smp_l = 16'(l); smp_r = 16'(r);
    tick(1);
    smp_vld = 0;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_code = 0; chan_en = 2'b11;
    zc_en = 0; to_en = 0; to_div = 0; smp_vld = 0; smp_l = 0; smp_r = 0;
    tick(3);
    // R1 reset state
    chk("R1", int'(gain_l), 0, "gain_l reset");
    chk("R1", int'(gain_r), 0, "gain_r reset");
    chk("R1", int'(mute), 3, "mute reset");
    chk("R1", int'(out_vld), 0, "out_vld reset");
    chk("R1", int'(out_l), 0, "out_l reset");
    rst_n = 1; cmp_on = 1;
    tick(1);

    // R3 immediate update
    wr(0, 121);
    strobe(1000, -500);
    chk("R3", int'(gain_l), 121, "unity applied");
    chk("R3", int'(out_l), 1000, "unity sample");
    chk("R2", int'(gain_r), 0, "right untouched");
    // R8 saturation
    wr(1, 127);
    strobe(20000, -20000);
    chk("R8", int'(out_r), -32768, "neg saturation");
    strobe(-20000, 20000);
    chk("R8", int'(out_r), 32767, "pos saturation");
    // R7 arithmetic
    wr(0, 115);
    strobe(16384, 0);
    chk("R7", int'(out_l), 8192, "-6 dB");
    // R9 threshold
    wr(0, 47);
    strobe(32767, 0);
    chk("R9", int'(mute[0]), 0, "code 47 live");
    chk("R9", int'(out_l), 7, "code 47 scale");
    wr(0, 46);
    strobe(32767, 0);
    chk("R9", int'(mute[0]), 1, "code 46 muted");
    chk("R9", int'(out_l), 0, "code 46 silent");

    // R4 zero-cross hold
    wr(0, 121);
    strobe(100, 5);
    zc_en = 1;
    wr(0, 100);
    strobe(200, 5);
    strobe(300, 5);
    chk("R4", int'(gain_l), 121, "held without crossing");
    strobe(-50, 5);
    chk("R4", int'(gain_l), 100, "applied at sign flip");
    chk("R4", int'(out_l), -5, "crossing sample scaled");
    wr(0, 110);
    strobe(-60, 5);
    chk("R4", int'(gain_l), 100, "no flip neg to neg");
    strobe(0, 5);
    chk("R4", int'(gain_l), 110, "applied at exact zero");

    // R6 rewrite replaces pending
    wr(0, 90);
    strobe(10, 5);
    wr(0, 80);
    strobe(10, 5);
    chk("R6", int'(gain_l), 110, "still pending");
    strobe(-10, 5);
    chk("R6", int'(gain_l), 80, "latest value wins");

    // R5 timeout, divider 0
    to_en = 1; to_div = 0;
    wr(0, 105);
    smp_vld = 1; smp_l = -7; smp_r = 5;
    tick(1023);
    chk("R5", int'(gain_l), 80, "before timeout");
    tick(1);
    chk("R5", int'(gain_l), 105, "at timeout");
    smp_vld = 0;
    // R6 restart of the count
    wr(0, 95);
    smp_vld = 1; tick(1000); smp_vld = 0;
    wr(0, 96);
    smp_vld = 1; tick(1000);
    chk("R6", int'(gain_l), 105, "count restarted");
    tick(24);
    chk("R6", int'(gain_l), 96, "restarted timeout");
    smp_vld = 0;
    // R5 divider 1
    to_div = 1;
    wr(0, 97);
    smp_vld = 1; tick(4095);
    chk("R5", int'(gain_l), 96, "before long timeout");
    tick(1);
    chk("R5", int'(gain_l), 97, "at long timeout");
    smp_vld = 0;

    // R10 disabled channel
    zc_en = 0; to_en = 0; to_div = 0;
    chan_en = 2'b10;
    wr(0, 121);
    strobe(500, 5);
    chk("R10", int'(out_l), 0, "disabled silent");
    chk("R10", int'(mute[0]), 1, "disabled mute");
    chk("R10", int'(gain_l), 121, "update continues");
    chan_en = 2'b11;
    strobe(500, 5);
    chk("R10", int'(out_l), 500, "re-enabled");

    // R2 right write only
    wr(1, 60);
    strobe(5, 5);
    chk("R2", int'(gain_l), 121, "left untouched");
    chk("R2", int'(gain_r), 60, "right written");

    // randomized traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        zc_en = 1'($urandom_range(0, 1));
        to_en = 1'($urandom_range(0, 1));
        chan_en = 2'($urandom_range(0, 3));
      end
      wr_en   = ($urandom_range(0, 7) == 0);
      wr_sel  = 1'($urandom_range(0, 1));
      wr_code = 7'($urandom_range(30, 127));
      smp_vld = ($urandom_range(0, 1) == 0);
      smp_l   = ($urandom_range(0, 9) == 0) ? 16'sd0 : 16'($urandom_range(0, 65535));
      smp_r   = 16'($urandom_range(0, 65535));
      tick(1);
    end
    wr_en = 0; smp_vld = 0;
    tick(2);
    report();
  end
endmodule